// File: doc/BRIEF.md
# Multi-Mode Lookup-Table Memory

This block is a 256-byte table store for a coarse-grain encryption cell. The same storage can be read in three ways. It can act as eight small tables, each taking a 4-bit address and giving a 4-bit result, with four pages per table. It can act as eight tables, each taking a 6-bit address and giving a 4-bit result. It can also act as one table that takes an 8-bit address and gives a byte. The storage is eight banks of 64 nibbles. Only the way the address lanes are spread over the banks changes between modes, and only the way the bank outputs are gathered into the 32-bit result.

Table contents are preloaded through a byte-wide write port, one byte per cycle. A lookup address presented on a clock edge produces its result one cycle later. The mode and the page are sampled on the same edge as the address.

Top module: `mm_lut_mem`

## Requirements
- R1: While reset is held and on the first cycle after it, `lookup_data` reads zero.
- R2: A write with `wr_en` high stores `wr_data` at byte address `wr_addr`. Bits [7:6] of the address pick a bank pair and bits [5:0] pick the entry. The low nibble goes to the even bank of the pair and the high nibble to the odd bank. A byte-mode read of the same address returns that byte.
- R3: Every lookup result appears on `lookup_data` exactly one clock edge after the address, mode and page are sampled.
- R4: With `cfg_mode` = 2 (byte mode), `lookup_addr[7:0]` selects the byte. The byte appears on `lookup_data[7:0]` and bits [31:8] read zero.
- R5: With `cfg_mode` = 1 (6-bit mode), table k takes `lookup_addr[6k+5:6k]` as the entry index into bank k and drives `lookup_data[4k+3:4k]`. Entry i of bank k is nibble (k mod 2) of byte address {k/2, i}.
- R6: With `cfg_mode` = 0 (4-bit mode), table k takes `lookup_addr[4k+3:4k]` as the low four index bits of bank k, and `page_sel` supplies index bits [5:4]. The result goes on nibble k. `lookup_addr[47:32]` has no effect.
- R7: A lookup that hits an entry written on the same edge returns the old contents. A lookup on the next edge returns the new contents.
- R8: With `cfg_mode` = 3 (idle), `lookup_data` reads zero one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the read path |
| cfg_mode | input | 2 | 0 = 4-bit paged, 1 = 6-bit, 2 = byte, 3 = idle |
| page_sel | input | 2 | Page for 4-bit mode |
| lookup_addr | input | 48 | Packed lookup address lanes |
| lookup_data | output | 32 | Packed lookup results |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 8 | Byte address for the write |
| wr_data | input | 8 | Byte to store |

## Verification
Every lookup result is due one edge after the address, mode and page are sampled. A write becomes visible to a lookup issued on the edge after the write. The bench drives inputs on the falling edge. At the next falling edge it compares the output with the value its reference model predicted from the previous stimulus. The model takes a snapshot of its table before it applies the write of that same cycle, so a read and a write to the same entry on one edge yield the old data.

// File: rtl/lutmem_pkg.sv
package lutmem_pkg;
   typedef enum logic [1:0] {
      MODE_NIB4  = 2'd0,
      MODE_NIB6  = 2'd1,
      MODE_BYTE8 = 2'd2,
      MODE_IDLE  = 2'd3
   } lut_mode_e;
endpackage

// File: rtl/lutmem_bank.sv
module lutmem_bank #(
   parameter int AW = 6,
   parameter int W  = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] rd_idx,
   input  logic          we,
   input  logic [AW-1:0] wr_idx,
   input  logic [W-1:0]  wr_nib,
   output logic [W-1:0]  rd_nib
);
   localparam int DEPTH = 1 << AW;

   logic [W-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) store[wr_idx] <= wr_nib;
   end

   // Read samples the array before this edge's write lands: old data on collision.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_nib <= '0;
      else        rd_nib <= store[rd_idx];
   end

   // R7: an entry written on one edge is returned by a read issued on the next edge.
   assert_write_then_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(we, 2) && ($past(wr_idx, 2) == $past(rd_idx)))
      |-> (rd_nib == $past(wr_nib, 2)));
endmodule

// File: rtl/lutmem_route.sv
module lutmem_route
   import lutmem_pkg::*;
#(
   parameter int N_BANK    = 8,
   parameter int BANK_AW   = 6,
   parameter int NARROW_AW = 4,
   parameter int PAGE_W    = BANK_AW - NARROW_AW
) (
   input  lut_mode_e                   mode,
   input  logic [N_BANK*BANK_AW-1:0]   addr,
   input  logic [PAGE_W-1:0]           page,
   output logic [N_BANK*BANK_AW-1:0]   idx
);
   for (genvar k = 0; k < N_BANK; k++) begin : g_lane
      always_comb begin
         unique case (mode)
            MODE_NIB4: idx[k*BANK_AW +: BANK_AW] = {page, addr[k*NARROW_AW +: NARROW_AW]};
            MODE_NIB6: idx[k*BANK_AW +: BANK_AW] = addr[k*BANK_AW +: BANK_AW];
            default:   idx[k*BANK_AW +: BANK_AW] = addr[BANK_AW-1:0];
         endcase
      end
   end
endmodule

// File: rtl/lutmem_pack.sv
module lutmem_pack
   import lutmem_pkg::*;
#(
   parameter int N_BANK = 8,
   parameter int NIB_W  = 4,
   parameter int PAIR_W = 2
) (
   input  lut_mode_e                 mode_q,
   input  logic [PAIR_W-1:0]         pair_q,
   input  logic [N_BANK*NIB_W-1:0]   nibs,
   output logic [N_BANK*NIB_W-1:0]   data
);
   localparam int N_PAIR = N_BANK / 2;
   localparam int BYTE_W = 2 * NIB_W;

   logic [BYTE_W-1:0] byte_sel;

   // One N_PAIR:1 multiplexer per result bit; the even bank feeds the low nibble.
   for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
      logic [N_PAIR-1:0] cand;
      for (genvar p = 0; p < N_PAIR; p++) begin : g_pair
         assign cand[p] = nibs[(2*p + b/NIB_W)*NIB_W + (b % NIB_W)];
      end
      assign byte_sel[b] = cand[pair_q];
   end

   always_comb begin
      unique case (mode_q)
         MODE_NIB4, MODE_NIB6: data = nibs;
         MODE_BYTE8:           data = {{(N_BANK*NIB_W-BYTE_W){1'b0}}, byte_sel};
         default:              data = '0;
      endcase
   end
endmodule

// File: rtl/mm_lut_mem.sv
module mm_lut_mem
   import lutmem_pkg::*;
#(
   parameter int N_BANK    = 8,
   parameter int BANK_AW   = 6,
   parameter int NARROW_AW = 4,
   parameter int NIB_W     = 4,
   localparam int PAIR_W   = $clog2(N_BANK / 2),
   localparam int BYTE_AW  = BANK_AW + PAIR_W,
   localparam int PAGE_W   = BANK_AW - NARROW_AW,
   localparam int ADDR_W   = N_BANK * BANK_AW,
   localparam int DATA_W   = N_BANK * NIB_W,
   localparam int BYTE_W   = 2 * NIB_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cfg_mode,
   input  logic [PAGE_W-1:0] page_sel,
   input  logic [ADDR_W-1:0] lookup_addr,
   output logic [DATA_W-1:0] lookup_data,
   input  logic              wr_en,
   input  logic [BYTE_AW-1:0] wr_addr,
   input  logic [BYTE_W-1:0] wr_data
);
   if (N_BANK < 4 || (N_BANK & (N_BANK - 1)) != 0) begin : g_chk_bank
      initial $error("N_BANK must be a power of two of at least 4");
   end
   if (NARROW_AW < 1 || NARROW_AW >= BANK_AW) begin : g_chk_aw
      initial $error("NARROW_AW must lie between 1 and BANK_AW-1");
   end

   lut_mode_e                 mode_in, mode_q;
   logic [PAIR_W-1:0]         pair_q;
   logic [ADDR_W-1:0]         bank_idx;
   logic [DATA_W-1:0]         bank_nibs;

   assign mode_in = lut_mode_e'(cfg_mode);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_NIB4;
         pair_q <= '0;
      end else begin
         mode_q <= mode_in;
         pair_q <= lookup_addr[BYTE_AW-1:BANK_AW];
      end
   end

   lutmem_route #(
      .N_BANK(N_BANK), .BANK_AW(BANK_AW), .NARROW_AW(NARROW_AW), .PAGE_W(PAGE_W)
   ) u_route (
      .mode(mode_in), .addr(lookup_addr), .page(page_sel), .idx(bank_idx)
   );

   for (genvar k = 0; k < N_BANK; k++) begin : g_bank
      logic we_k;
      assign we_k = wr_en && (wr_addr[BYTE_AW-1:BANK_AW] == PAIR_W'(k / 2));
      lutmem_bank #(.AW(BANK_AW), .W(NIB_W)) u_bank (
         .clk(clk), .rst_n(rst_n),
         .rd_idx(bank_idx[k*BANK_AW +: BANK_AW]),
         .we(we_k),
         .wr_idx(wr_addr[BANK_AW-1:0]),
         .wr_nib(wr_data[(k % 2)*NIB_W +: NIB_W]),
         .rd_nib(bank_nibs[k*NIB_W +: NIB_W])
      );
   end

   lutmem_pack #(.N_BANK(N_BANK), .NIB_W(NIB_W), .PAIR_W(PAIR_W)) u_pack (
      .mode_q(mode_q), .pair_q(pair_q), .nibs(bank_nibs), .data(lookup_data)
   );

   // R6: in paged mode every bank index carries the page in its upper bits.
   always_comb begin
      if (rst_n && mode_in == MODE_NIB4) begin
         for (int k = 0; k < N_BANK; k++) begin
            assert_page_bits_R6: assert (bank_idx[k*BANK_AW + NARROW_AW +: PAGE_W] == page_sel);
         end
      end
   end

   // R8: idle mode gives an all-zero result one cycle later.
   assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cfg_mode) == 2'd3) |-> (lookup_data == '0));

   // R4: byte mode leaves every bit above the byte at zero.
   assert_byte_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cfg_mode) == 2'd2) |-> (lookup_data[DATA_W-1:BYTE_W] == '0));

   // R1: the cycle after reset is released still shows zero.
   assert_reset_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(rst_n)) |-> (lookup_data == '0));
endmodule

// File: tb/tb_mm_lut_mem.sv
module tb_mm_lut_mem;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cfg_mode = 2'd3;
   logic [1:0]  page_sel = '0;
   logic [47:0] lookup_addr = '0;
   logic [31:0] lookup_data;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [7:0]  wr_data = '0;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   logic [7:0]  model [256];
   logic [31:0] exp_q = '0;
   string       exp_tag = "R1";

   always #10 clk = ~clk;

   mm_lut_mem dut (
      .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .page_sel(page_sel),
      .lookup_addr(lookup_addr), .lookup_data(lookup_data),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
   );

   function automatic logic [3:0] nib(int k, logic [5:0] i);
      logic [7:0] b;
      b = model[{k[2:1], i}];
      return k[0] ? b[7:4] : b[3:0];
   endfunction

   function automatic logic [31:0] predict(logic [1:0] m, logic [47:0] a, logic [1:0] pg);
      logic [31:0] r;
      r = '0;
      case (m)
         2'd0: for (int k = 0; k < 8; k++) r[4*k +: 4] = nib(k, {pg, a[4*k +: 4]});
         2'd1: for (int k = 0; k < 8; k++) r[4*k +: 4] = nib(k, a[6*k +: 6]);
         2'd2: r[7:0] = model[a[7:0]];
         default: r = '0;
      endcase
      return r;
   endfunction

   function automatic string mode_tag(logic [1:0] m);
      case (m)
         2'd0: return "R6";
         2'd1: return "R5";
         2'd2: return "R4";
         default: return "R8";
      endcase
   endfunction

   task automatic check_out();
      checks++;
      if (lookup_data !== exp_q) begin
         errors++;
         $display("FAIL %s/R3: lookup_data=%h expected=%h", exp_tag, lookup_data, exp_q);
      end
   endtask

   // Check the result of the previous stimulus, then drive the next one.
   task automatic step(logic [1:0] m, logic [47:0] a, logic [1:0] pg,
                       logic we, logic [7:0] wa, logic [7:0] wd, string tag);
      @(negedge clk);
      check_out();
      cfg_mode = m; lookup_addr = a; page_sel = pg;
      wr_en = we; wr_addr = wa; wr_data = wd;
      exp_q = predict(m, a, pg);
      exp_tag = tag;
      if (we) model[wa] = wd;
   endtask

   function automatic logic [47:0] rnd48();
      return {16'($urandom), 32'($urandom)};
   endfunction

   initial begin
      for (int i = 0; i < 256; i++) model[i] = '0;
      // R1: reset state
      repeat (3) begin
         @(negedge clk);
         check_out();
      end
      rst_n = 1'b1;
      exp_q = '0; exp_tag = "R1";
      // R2/R8: preload every byte while idle
      for (int a = 0; a < 256; a++)
         step(2'd3, rnd48(), 2'($urandom), 1'b1, 8'(a), 8'((a * 37 + 11) & 255), "R8");
      // R2/R4: byte reads of every address
      for (int a = 0; a < 256; a++)
         step(2'd2, {40'(rnd48()), 8'(a)}, 2'($urandom), 1'b0, '0, '0, "R2");
      // R4/R5/R6/R8: mixed traffic with occasional writes
      for (int n = 0; n < 3000; n++) begin
         logic [1:0] m;
         m = 2'($urandom);
         step(m, rnd48(), 2'($urandom), ($urandom % 4) == 0,
              8'($urandom), 8'($urandom), mode_tag(m));
      end
      // R7: same-edge collision returns old data, next edge returns new
      for (int n = 0; n < 24; n++) begin
         logic [7:0] a;
         a = 8'($urandom);
         step(2'd2, {40'(rnd48()), a}, 2'd0, 1'b1, a, 8'($urandom), "R7");
         step(2'd2, {40'(rnd48()), a}, 2'd0, 1'b0, '0, '0, "R7");
      end
      // R6: page selection across all pages with fixed lanes
      for (int pg = 0; pg < 4; pg++)
         step(2'd0, 48'h1234_5678_9abc, 2'(pg), 1'b0, '0, '0, "R6");
      step(2'd3, '0, '0, 1'b0, '0, '0, "R8");
      @(negedge clk);
      check_out();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule